// File: doc/BRIEF.md
# K28.5 Comma Word Aligner

This block takes a recovered serial bit stream, one bit per bit-clock cycle, and cuts it into 10-bit receive words. While framing is enabled it watches every bit position for the seven-bit comma that opens a K28.5 character. When a comma is found away from the current word boundary, the boundary is moved so that the comma opens a word. Each presented word comes with a one-cycle byte-clock strobe and, if the word starts with the comma, a SYNC flag.

The byte clocks are modelled as enable strobes in the bit-clock domain. In full-rate mode every word is marked on strobe 0. In half-rate mode the words alternate between the two strobes, and a comma word always lands on strobe 1. A realignment only ever lengthens the spacing between strobes. The block sits behind clock and data recovery and ahead of the word decoder.

Top module: `comma_word_aligner`

## Requirements
- R1: Each presented word holds ten consecutive received bits, and the earliest bit sits in `rx_word[0]`. After reset the first boundary lies before the first bit sampled, so words are presented on bits 9, 19, 29 and so on. The K28.5 word therefore reads 10'h17C.
- R2: While `sync_en` is low the boundary never moves and `sync_out` stays low, even when the stream contains a comma.
- R3: A comma whose first bit falls on the current boundary causes no realignment, and the word cadence stays at 10 cycles.
- R4: The comma is the received sequence 0,0,1,1,1,1,1. If it is found with its last bit at in-word position p (p not 6, with positions 0..9 counted from the boundary), the boundary moves so that the comma opens a word. Neither the old word in progress nor the comma word itself is presented. The next strobe comes p+14 cycles after the previous one, and all later words are aligned to the new boundary.
- R5: Successive strobes are never closer than 10 cycles. A single realignment adds no more than 20 cycles to the spacing.
- R6: `sync_out` rises with a presented word whose first seven bits are the comma, but only while `sync_en` is high. It stays high for exactly that word and drops at the next strobe.
- R7: With `full_rate` high every word is marked by `bclk0_en` and `bclk1_en` stays low.
- R8: With `full_rate` low, strobes alternate between the two lanes. The first word after reset uses `bclk1_en`, and a comma word always uses `bclk1_en`.
- R9: Each strobe lasts one cycle and at most one strobe is high at a time. `rx_word` and `sync_out` change only with a strobe.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Serial data, one bit per cycle |
| sync_en | input | 1 | Enables comma search and SYNC |
| full_rate | input | 1 | 1: one full-rate byte clock; 0: two half-rate lanes |
| rx_word | output | 10 | Presented word, earliest bit in bit 0 |
| bclk0_en | output | 1 | Byte-clock strobe, lane 0 |
| bclk1_en | output | 1 | Byte-clock strobe, lane 1 |
| sync_out | output | 1 | Presented word starts with the comma |

## Verification
On every cycle the assertions check four things: the minimum strobe spacing, the lane exclusivity, and that the word and SYNC hold between strobes. They also check that SYNC only accompanies a comma-headed word on the proper lane, and that half-rate lanes alternate. Only the bench scenarios can show where the boundary lands after each of the ten possible comma offsets, the exact p+14 stretch, and which words are dropped. The same goes for the unframed behaviour with framing disabled, which the bench runs in both clock modes.

// File: rtl/cwa_pkg.sv
// Shared constants for the comma word aligner.
// Assumes the comma is shorter than a word.
package cwa_pkg;
    localparam int WORD_W = 10;
    localparam int MARK_W = 7;
    // bit i holds the i-th received bit of the comma (0,0,1,1,1,1,1)
    localparam logic [MARK_W-1:0] MARK_PAT = 7'b1111100;
endpackage

// File: rtl/cwa_bit_window.sv
// Sliding window over the most recent WORD_W received bits.
// word_now includes the bit presented this cycle; bit 0 is the oldest.
// Assumes MARK_W <= WORD_W.
module cwa_bit_window #(
    parameter int WORD_W = cwa_pkg::WORD_W,
    parameter int MARK_W = cwa_pkg::MARK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    output logic [WORD_W-1:0] word_now,
    output logic [MARK_W-1:0] mark_now
);
    logic [WORD_W-2:0] hist;

    // shift the newest bit in at the top, oldest falls out at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {rx_bit, hist[WORD_W-2:1]};
    end

    assign word_now = {rx_bit, hist};
    assign mark_now = word_now[WORD_W-1 -: MARK_W];
endmodule

// File: rtl/cwa_boundary.sv
// Tracks the position of the current bit inside the word and moves the
// word boundary when a comma is found off the boundary. After a move the
// first completion on the new boundary (the comma word) is suppressed, so
// byte-clock spacing only grows. Assumes MARK_W < WORD_W.
module cwa_boundary #(
    parameter int                 WORD_W   = cwa_pkg::WORD_W,
    parameter int                 MARK_W   = cwa_pkg::MARK_W,
    parameter logic [MARK_W-1:0]  MARK_PAT = cwa_pkg::MARK_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic [MARK_W-1:0] mark_now,
    output logic              word_done
);
    localparam int              POS_W    = $clog2(WORD_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);
    localparam logic [POS_W-1:0] MARK_END = POS_W'(MARK_W - 1);
    localparam logic [POS_W-1:0] RESUME   = POS_W'(MARK_W);

    logic [POS_W-1:0] pos;
    logic             skip;
    logic             hit;
    logic             shift_req;

    // a comma ending anywhere but MARK_END needs the boundary moved
    always_comb begin
        hit       = sync_en && (mark_now == MARK_PAT);
        shift_req = hit && (pos != MARK_END);
        word_done = (pos == LAST_POS) && !shift_req && !skip;
    end

    // advance the in-word position, or jump it on a realignment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            skip <= 1'b0;
        end else if (shift_req) begin
            pos  <= RESUME;
            skip <= 1'b1;
        end else if (pos == LAST_POS) begin
            pos  <= '0;
            skip <= 1'b0;
        end else begin
            pos  <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/cwa_lane_steer.sv
// Registers each completed word, raises SYNC for comma-headed words and
// steers the byte-clock strobe: lane 0 only in full-rate mode, alternating
// lanes in half-rate mode with comma words forced onto lane 1.
module cwa_lane_steer #(
    parameter int                 WORD_W   = cwa_pkg::WORD_W,
    parameter int                 MARK_W   = cwa_pkg::MARK_W,
    parameter logic [MARK_W-1:0]  MARK_PAT = cwa_pkg::MARK_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_now,
    input  logic              sync_en,
    input  logic              full_rate,
    output logic [WORD_W-1:0] rx_word,
    output logic              bclk0_en,
    output logic              bclk1_en,
    output logic              sync_out
);
    logic head;
    logic last_b;

    // comma at the head of the completing word, only while framing
    always_comb head = sync_en && (word_now[MARK_W-1:0] == MARK_PAT);

    // present the word and pulse the chosen lane for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word  <= '0;
            sync_out <= 1'b0;
            bclk0_en <= 1'b0;
            bclk1_en <= 1'b0;
            last_b   <= 1'b0;
        end else begin
            bclk0_en <= 1'b0;
            bclk1_en <= 1'b0;
            if (word_done) begin
                rx_word  <= word_now;
                sync_out <= head;
                if (full_rate) begin
                    bclk0_en <= 1'b1;
                    last_b   <= 1'b0;
                end else if (head || !last_b) begin
                    bclk1_en <= 1'b1;
                    last_b   <= 1'b1;
                end else begin
                    bclk0_en <= 1'b1;
                    last_b   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/comma_word_aligner.sv
// Comma word aligner top: bit window, boundary tracker and lane steering.
// Runs entirely on the recovered bit clock; byte clocks leave as strobes.
module comma_word_aligner #(
    parameter int                 WORD_W   = cwa_pkg::WORD_W,
    parameter int                 MARK_W   = cwa_pkg::MARK_W,
    parameter logic [MARK_W-1:0]  MARK_PAT = cwa_pkg::MARK_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              sync_en,
    input  logic              full_rate,
    output logic [WORD_W-1:0] rx_word,
    output logic              bclk0_en,
    output logic              bclk1_en,
    output logic              sync_out
);
    logic [WORD_W-1:0] word_now;
    logic [MARK_W-1:0] mark_now;
    logic              word_done;

    cwa_bit_window #(.WORD_W(WORD_W), .MARK_W(MARK_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_bit),
        .word_now (word_now),
        .mark_now (mark_now)
    );

    cwa_boundary #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT)) u_boundary (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en),
        .mark_now  (mark_now),
        .word_done (word_done)
    );

    cwa_lane_steer #(.WORD_W(WORD_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_now  (word_now),
        .sync_en   (sync_en),
        .full_rate (full_rate),
        .rx_word   (rx_word),
        .bclk0_en  (bclk0_en),
        .bclk1_en  (bclk1_en),
        .sync_out  (sync_out)
    );
endmodule

// File: rtl/comma_word_aligner_chk.sv
// Property checker for the comma word aligner, bound to every instance.
// Tracks strobe spacing and the last lane used with small counters.
module comma_word_aligner_chk #(
    parameter int                 WORD_W   = cwa_pkg::WORD_W,
    parameter int                 MARK_W   = cwa_pkg::MARK_W,
    parameter logic [MARK_W-1:0]  MARK_PAT = cwa_pkg::MARK_PAT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_bit,
    input logic              sync_en,
    input logic              full_rate,
    input logic [WORD_W-1:0] rx_word,
    input logic              bclk0_en,
    input logic              bclk1_en,
    input logic              sync_out
);
    localparam int GAP_W = $clog2(4 * WORD_W);

    logic             past_ok;
    logic             seen;
    logic             prev_l1;
    logic [GAP_W-1:0] idle_cnt;
    logic             any_stb;
    logic             unused_in;

    always_comb any_stb = bclk0_en || bclk1_en;
    always_comb unused_in = rx_bit;

    // count idle cycles since the last strobe and remember its lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            seen     <= 1'b0;
            prev_l1  <= 1'b0;
            idle_cnt <= '0;
        end else begin
            past_ok <= 1'b1;
            if (any_stb) begin
                seen     <= 1'b1;
                prev_l1  <= bclk1_en;
                idle_cnt <= '0;
            end else if (idle_cnt != '1) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assert_lane_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bclk0_en, bclk1_en}));

    assert_min_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && seen) |-> (idle_cnt >= GAP_W'(WORD_W - 1)));

    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !any_stb) |-> ($stable(rx_word) && $stable(sync_out)));

    assert_full_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(full_rate)) |-> !bclk1_en);

    assert_sync_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (rx_word[MARK_W-1:0] == MARK_PAT));

    assert_sync_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sync_out)) |-> $past(sync_en));

    assert_sync_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(full_rate) && any_stb && sync_out) |-> bclk1_en);

    assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(full_rate) && seen && any_stb && !sync_out) |-> (bclk1_en != prev_l1));
endmodule

bind comma_word_aligner comma_word_aligner_chk #(
    .WORD_W(WORD_W), .MARK_W(MARK_W), .MARK_PAT(MARK_PAT)
) u_chk (.*);

// File: tb/comma_word_aligner_test.sv
// Sweeps the comma over all ten in-word offsets in both clock modes,
// plus unframed runs, and compares every strobe against expectations
// derived from the bit stream the bench builds.
module comma_word_aligner_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 128;
    localparam int MAXR = 32;
    localparam logic [9:0] K28_5 = 10'h17C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       sync_en = 1'b0;
    logic       full_rate = 1'b1;
    logic [9:0] rx_word;
    logic       bclk0_en, bclk1_en, sync_out;

    comma_word_aligner uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_en(sync_en),
        .full_rate(full_rate), .rx_word(rx_word), .bclk0_en(bclk0_en),
        .bclk1_en(bclk1_en), .sync_out(sync_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int sent = 0;
    logic stream [MAXB];
    int rec_n = 0;
    int rec_end [MAXR];
    logic [9:0] rec_word [MAXR];
    logic rec_sync [MAXR];
    logic rec_l1 [MAXR];
    int exp_n;
    int exp_end [MAXR];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // record strobes a quarter period after the edge; check hold and exclusivity
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            if (bclk0_en || bclk1_en) begin
                check(!(bclk0_en && bclk1_en), "R9 exclusive", int'(bclk1_en), 0);
                if (rec_n < MAXR) begin
                    rec_end[rec_n]  = sent - 1;
                    rec_word[rec_n] = rx_word;
                    rec_sync[rec_n] = sync_out;
                    rec_l1[rec_n]   = bclk1_en;
                    rec_n++;
                end
            end else if (rec_n > 0) begin
                check(rx_word == rec_word[rec_n-1], "R9 hold", int'(rx_word), int'(rec_word[rec_n-1]));
            end
        end
    end

    task automatic fill_filler();
        for (int i = 0; i < MAXB; i++) stream[i] = (i % 2 == 0);
    endtask

    task automatic put_word(input int start, input logic [9:0] w);
        for (int j = 0; j < 10; j++) stream[start+j] = w[j];
    endtask

    task automatic run(input int nb);
        @(negedge clk);
        rst_n = 1'b0;
        rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        rec_n = 0;
        sent = 0;
        rst_n = 1'b1;
        rx_bit = stream[0];
        sent = 1;
        for (int i = 1; i < nb; i++) begin
            @(negedge clk);
            rx_bit = stream[i];
            sent = i + 1;
        end
        @(posedge clk);
        #(CLK_PERIOD/2);
        rst_n = 1'b0;
    endtask

    // compare recorded strobes with exp_end[] and rules R1, R5..R8
    task automatic compare_run(input string req);
        logic [9:0] w;
        logic es, prev1, el1;
        int lim;
        prev1 = 1'b0;
        check(rec_n == exp_n, req, rec_n, exp_n);
        lim = (rec_n < exp_n) ? rec_n : exp_n;
        for (int k = 0; k < lim; k++) begin
            check(rec_end[k] == exp_end[k], req, rec_end[k], exp_end[k]);
            for (int j = 0; j < 10; j++) w[j] = stream[exp_end[k]-9+j];
            check(rec_word[k] == w, "R1 word", int'(rec_word[k]), int'(w));
            es = sync_en && (w == K28_5);
            check(rec_sync[k] == es, "R6 sync", int'(rec_sync[k]), int'(es));
            if (full_rate) el1 = 1'b0;
            else el1 = es || !prev1;
            prev1 = el1;
            check(rec_l1[k] == el1, full_rate ? "R7 lane" : "R8 lane", int'(rec_l1[k]), int'(el1));
            if (k > 0) begin
                check(rec_end[k] - rec_end[k-1] >= 10, "R5 min gap", rec_end[k] - rec_end[k-1], 10);
                check(rec_end[k] - rec_end[k-1] <= 30, "R5 max gap", rec_end[k] - rec_end[k-1], 30);
            end
        end
    endtask

    // comma at offset s after 20 filler bits, second comma 20 bits later
    task automatic sweep_case(input int s, input bit half, input bit framed);
        int cs, d, nb, e;
        cs = 20 + s;
        d = cs + 6;
        nb = cs + 45;
        fill_filler();
        put_word(cs, K28_5);
        put_word(cs + 20, K28_5);
        full_rate = !half;
        sync_en = framed;
        exp_n = 0;
        if (!framed || s == 0) begin
            for (int x = 9; x < nb; x += 10) begin exp_end[exp_n] = x; exp_n++; end
        end else begin
            e = 9;
            while (e < d) begin exp_end[exp_n] = e; exp_n++; e += 10; end
            // R4: realigned strobe lands p+14 after the previous one
            for (int x = d + 13; x < nb; x += 10) begin exp_end[exp_n] = x; exp_n++; end
        end
        run(nb);
        if (!framed) compare_run("R2 unframed");
        else if (s == 0) compare_run("R3 aligned");
        else compare_run("R4 realign");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", n_cmp, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: outputs low while reset is held, even with data toggling
        rst_n = 1'b0;
        sync_en = 1'b1;
        repeat (4) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
        check(rx_word == 10'd0, "R10 word", int'(rx_word), 0);
        check(!bclk0_en && !bclk1_en, "R10 strobes", int'({bclk1_en, bclk0_en}), 0);
        check(!sync_out, "R10 sync", int'(sync_out), 0);

        for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 10; s++) sweep_case(s, h[0], 1'b1);
            sweep_case(4, h[0], 1'b0);
            sweep_case(7, h[0], 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule